// File: doc/BRIEF.md
# Calendar Clock Update Engine

This block keeps wall-clock time (seconds, minutes, hours, day of month, month, two-digit year and century) and moves it forward once per second. Its time base is a tick enable at 32.768 kHz, divided by a free-running phase counter. Software reaches the block through a byte-wide register port. It writes the time and date, controls the divider, freezes the clock while loading a new time, and reads back an update-in-progress bit and the event flags.

The timing of an update is exact. A divider held in reset does not advance time. Releasing the divider places the first update half a second later. The update-in-progress bit is visible for a fixed window of divider ticks ending at the update instant. It is computed from the divider phase, so no later register write can leave it raised. Each update sets an update-ended flag. When a three-field alarm (hour, minute, second) matches the new time, the update also sets an alarm flag. Reading the status register clears both flags.

Register values are packed BCD or binary, selected by a mode bit. The clock always runs in 24-hour form.

Top module: `rtc_update_core`

## Requirements
- R1: Writing the control register (index 10) with bits 6:4 equal to 110 or 111 (for example 0x76) stops the divider. While it is stopped the time and date registers never change, however many ticks arrive.
- R2: Writing control bits 6:4 = 010 (for example 0x26) while the divider is stopped starts it. The first update happens exactly TICKS_PER_SEC/2 ticks after the releasing write. Before that update the seconds register keeps its old value, and after it the seconds are one higher.
- R3: Control bit 7 (update in progress) reads 1 for exactly the HOLD_TICKS ticks before each update. It reads 0 one tick earlier and again right after the update. The time registers do not change during that window.
- R4: While mode register (index 11) bit 7 is 1, time does not advance, writes to the time registers take effect, no update-ended flag is raised, and control bit 7 reads 0. When bit 7 is cleared, counting resumes, and within one second the seconds register goes up by exactly one.
- R5: Mode bit 2 set makes every time and date register (read and write) plain binary. Mode bit 2 clear makes them packed BCD. Changing the bit reinterprets the same stored time.
- R6: Control bit 7 is derived only from the divider phase. Rewriting the alarm registers while it reads 1 does not extend it, and it still clears at the update.
- R7: Every update sets status register (index 12) bit 4. A read of the status register clears bits 4 and 5, unless an update happens on the same cycle as the read. A second read returns 0x00.
- R8: An update sets status bit 5 when the alarm hour (index 5), minute (3) and second (1) registers each equal the new time in the current data format. An alarm byte with bits 7:6 = 11 matches any value.
- R9: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 and carry into hours. Hours wrap from 23 and carry into the day.
- R10: The day wraps after 30 days in April, June, September and November, and after 31 days in the other months. February has 29 days when the two-digit year is a multiple of 4, otherwise 28. Month 12 wraps to 1 and carries into the year. Year 99 wraps to 0 and carries into the century (index 0x32).
- R11: Seconds, minutes, hours, day, month and year are at indices 0, 2, 4, 7, 8 and 9. Unmapped indices read 0x00. After reset the time reads 00:00:00, 01/01, year 00, century 0x20, control 0x26, mode 0x02 and status 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 32.768 kHz divider tick enable, one clk cycle wide |
| wr | input | 1 | Register write strobe, sampled on the rising edge |
| rd | input | 1 | Register read strobe; only a status read has a side effect |
| addr | input | 8 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current index (combinational) |

## Verification
A wrong divider phase shows up as the update-in-progress bit or the seconds step landing on the wrong tick. The bench samples both one tick before and one tick after each expected edge, so an off-by-one is reported in the cycle it happens. A wrong carry or month-length decision shows up in the first update after the loaded corner date, which is half a second after release. A flag that is set or cleared wrongly shows up on the next status read, which is taken right after the update it should reflect.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [4:0] hour;
    logic [4:0] day;
    logic [3:0] mon;
    logic [6:0] year;
    logic [6:0] cent;
  } rtc_time_t;

  typedef enum logic [2:0] {
    F_SEC, F_MIN, F_HOUR, F_DAY, F_MON, F_YEAR, F_CENT, F_NONE
  } field_e;

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [7:0] r;
    r[7:4] = 4'(v / 7'd10);
    r[3:0] = 4'(v % 7'd10);
    return r;
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [4:0] days_in_month(input logic [3:0] m, input logic [6:0] y);
    case (m)
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      4'd2:                    return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
      default:                 return 5'd31;
    endcase
  endfunction

  function automatic rtc_time_t next_time(input rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.sec < 7'd59) n.sec = t.sec + 7'd1;
    else begin
      n.sec = 7'd0;
      if (t.min < 7'd59) n.min = t.min + 7'd1;
      else begin
        n.min = 7'd0;
        if (t.hour < 5'd23) n.hour = t.hour + 5'd1;
        else begin
          n.hour = 5'd0;
          if (t.day < days_in_month(t.mon, t.year)) n.day = t.day + 5'd1;
          else begin
            n.day = 5'd1;
            if (t.mon < 4'd12) n.mon = t.mon + 4'd1;
            else begin
              n.mon = 4'd1;
              if (t.year < 7'd99) n.year = t.year + 7'd1;
              else begin
                n.year = 7'd0;
                n.cent = (t.cent < 7'd99) ? t.cent + 7'd1 : 7'd0;
              end
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int HOLD_TICKS    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic release_go,
  output logic uip_raw,
  output logic upd_go
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST  = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF  = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] WSTART = CW'(TICKS_PER_SEC - HOLD_TICKS);

  logic [CW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else if (release_go) phase <= HALF;
    else if (run && tick) phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end

  assign upd_go  = run && tick && (phase == LAST) && !release_go;
  assign uip_raw = run && (phase >= WSTART);

  AST_UIP_AT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_go |-> uip_raw); // R3
  AST_UIP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_go |=> !uip_raw); // R3
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      upd_en,
  input  logic      wr_en,
  input  field_e    wr_field,
  input  logic [6:0] wr_val,
  output rtc_time_t now,
  output rtc_time_t nxt
);
  rtc_time_t t;

  assign nxt = next_time(t);
  assign now = t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t.sec  <= 7'd0;
      t.min  <= 7'd0;
      t.hour <= 5'd0;
      t.day  <= 5'd1;
      t.mon  <= 4'd1;
      t.year <= 7'd0;
      t.cent <= 7'd20;
    end else begin
      if (upd_en) t <= nxt;
      if (wr_en) begin
        case (wr_field)
          F_SEC:   t.sec  <= wr_val;
          F_MIN:   t.min  <= wr_val;
          F_HOUR:  t.hour <= wr_val[4:0];
          F_DAY:   t.day  <= wr_val[4:0];
          F_MON:   t.mon  <= wr_val[3:0];
          F_YEAR:  t.year <= wr_val;
          F_CENT:  t.cent <= wr_val;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  logic       clr,
  input  logic [7:0] now_sec,
  input  logic [7:0] now_min,
  input  logic [7:0] now_hour,
  input  logic [7:0] al_sec,
  input  logic [7:0] al_min,
  input  logic [7:0] al_hour,
  output logic       uf,
  output logic       af
);
  function automatic logic field_hit(input logic [7:0] a, input logic [7:0] v);
    return (a[7:6] == 2'b11) || (a == v);
  endfunction

  logic hit;
  assign hit = field_hit(al_sec, now_sec) && field_hit(al_min, now_min) &&
               field_hit(al_hour, now_hour);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf <= 1'b0;
      af <= 1'b0;
    end else begin
      if (upd) uf <= 1'b1;
      else if (clr) uf <= 1'b0;
      if (upd && hit) af <= 1'b1;
      else if (clr) af <= 1'b0;
    end
  end

  AST_UF_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> uf); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !upd) |=> (!uf && !af)); // R7
  AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && hit) |=> af); // R8
endmodule

// File: rtl/rtc_update_core.sv
module rtc_update_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int HOLD_TICKS    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam logic [7:0] IX_SEC  = 8'd0;
  localparam logic [7:0] IX_ASEC = 8'd1;
  localparam logic [7:0] IX_MIN  = 8'd2;
  localparam logic [7:0] IX_AMIN = 8'd3;
  localparam logic [7:0] IX_HOUR = 8'd4;
  localparam logic [7:0] IX_AHR  = 8'd5;
  localparam logic [7:0] IX_DAY  = 8'd7;
  localparam logic [7:0] IX_MON  = 8'd8;
  localparam logic [7:0] IX_YEAR = 8'd9;
  localparam logic [7:0] IX_CTRL = 8'd10;
  localparam logic [7:0] IX_MODE = 8'd11;
  localparam logic [7:0] IX_STAT = 8'd12;
  localparam logic [7:0] IX_CENT = 8'h32;
  localparam logic [2:0] DV_RUN  = 3'b010;

  logic [2:0] ctrl_dv;
  logic [3:0] ctrl_rate;
  logic [7:0] mode_r;
  logic [7:0] al_sec, al_min, al_hour;

  logic set_b, dm_b, run, release_go, uip_raw, upd_go, upd_eff, uip_vis;
  logic uf, af, stat_clr, time_wr;
  field_e wr_field;
  logic [6:0] wr_val;
  rtc_time_t cal_now, cal_nxt;

  function automatic logic [7:0] enc(input logic bin, input logic [6:0] v);
    return bin ? {1'b0, v} : to_bcd(v);
  endfunction

  assign set_b = mode_r[7];
  assign dm_b  = mode_r[2];
  assign run   = (ctrl_dv == DV_RUN);
  assign release_go = wr && (addr == IX_CTRL) && (wdata[6:4] == DV_RUN) && !run;
  assign upd_eff = upd_go && !set_b;
  assign uip_vis = uip_raw && !set_b;
  assign stat_clr = rd && (addr == IX_STAT);

  always_comb begin
    case (addr)
      IX_SEC:  wr_field = F_SEC;
      IX_MIN:  wr_field = F_MIN;
      IX_HOUR: wr_field = F_HOUR;
      IX_DAY:  wr_field = F_DAY;
      IX_MON:  wr_field = F_MON;
      IX_YEAR: wr_field = F_YEAR;
      IX_CENT: wr_field = F_CENT;
      default: wr_field = F_NONE;
    endcase
  end
  assign time_wr = wr && (wr_field != F_NONE);
  assign wr_val  = dm_b ? wdata[6:0] : from_bcd(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_dv   <= DV_RUN;
      ctrl_rate <= 4'h6;
      mode_r    <= 8'h02;
      al_sec    <= 8'h00;
      al_min    <= 8'h00;
      al_hour   <= 8'h00;
    end else if (wr) begin
      case (addr)
        IX_CTRL: begin ctrl_dv <= wdata[6:4]; ctrl_rate <= wdata[3:0]; end
        IX_MODE: mode_r  <= wdata;
        IX_ASEC: al_sec  <= wdata;
        IX_AMIN: al_min  <= wdata;
        IX_AHR:  al_hour <= wdata;
        default: ;
      endcase
    end
  end

  rtc_divider #(.TICKS_PER_SEC(TICKS_PER_SEC), .HOLD_TICKS(HOLD_TICKS)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .release_go(release_go),
    .uip_raw(uip_raw), .upd_go(upd_go)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_eff), .wr_en(time_wr),
    .wr_field(wr_field), .wr_val(wr_val), .now(cal_now), .nxt(cal_nxt)
  );

  rtc_flags u_flg (
    .clk(clk), .rst_n(rst_n), .upd(upd_eff), .clr(stat_clr),
    .now_sec(enc(dm_b, cal_nxt.sec)), .now_min(enc(dm_b, cal_nxt.min)),
    .now_hour(enc(dm_b, {2'b00, cal_nxt.hour})),
    .al_sec(al_sec), .al_min(al_min), .al_hour(al_hour), .uf(uf), .af(af)
  );

  always_comb begin
    case (addr)
      IX_SEC:  rdata = enc(dm_b, cal_now.sec);
      IX_ASEC: rdata = al_sec;
      IX_MIN:  rdata = enc(dm_b, cal_now.min);
      IX_AMIN: rdata = al_min;
      IX_HOUR: rdata = enc(dm_b, {2'b00, cal_now.hour});
      IX_AHR:  rdata = al_hour;
      IX_DAY:  rdata = enc(dm_b, {2'b00, cal_now.day});
      IX_MON:  rdata = enc(dm_b, {3'b000, cal_now.mon});
      IX_YEAR: rdata = enc(dm_b, cal_now.year);
      IX_CENT: rdata = enc(dm_b, cal_now.cent);
      IX_CTRL: rdata = {uip_vis, ctrl_dv, ctrl_rate};
      IX_MODE: rdata = mode_r;
      IX_STAT: rdata = {2'b00, af, uf, 4'h0};
      default: rdata = 8'h00;
    endcase
  end

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !time_wr) |=> $stable(cal_now)); // R1
  AST_SET_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_b && !time_wr) |=> $stable(cal_now)); // R4
endmodule

// File: tb/test_rtc_update_core.sv
module test_rtc_update_core;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int TPS  = 64;
  localparam int HOLD = 8;
  localparam int HALF = TPS / 2;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  rtc_update_core #(.TICKS_PER_SEC(TPS), .HOLD_TICKS(HOLD)) i_rtc_update_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr(wr), .rd(rd),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
    addr = a; #0.1; v = rdata;
  endtask

  task automatic rd_status(output logic [7:0] v);
    addr = 8'd12; rd = 1'b1; #0.1; v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic load(input logic [7:0] h, mi, s, d, mo, y, c);
    wr_reg(8'd4, h); wr_reg(8'd2, mi); wr_reg(8'd0, s);
    wr_reg(8'd7, d); wr_reg(8'd8, mo); wr_reg(8'd9, y); wr_reg(8'h32, c);
  endtask

  task automatic check_time(input string req, input logic [7:0] h, mi, s, d, mo, y, c);
    logic [7:0] v;
    rd_reg(8'd4, v);  chk(req, "hour", v, h);
    rd_reg(8'd2, v);  chk(req, "min", v, mi);
    rd_reg(8'd0, v);  chk(req, "sec", v, s);
    rd_reg(8'd7, v);  chk(req, "day", v, d);
    rd_reg(8'd8, v);  chk(req, "month", v, mo);
    rd_reg(8'd9, v);  chk(req, "year", v, y);
    rd_reg(8'h32, v); chk(req, "century", v, c);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check_time("R11", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h20);
    rd_reg(8'd10, v); chk("R11", "control", v, 8'h26);
    rd_reg(8'd11, v); chk("R11", "mode", v, 8'h02);
    rd_reg(8'd12, v); chk("R11", "status", v, 8'h00);
    rd_reg(8'd6, v);  chk("R11", "unmapped", v, 8'h00);
  endtask

  task automatic t_divider;
    logic [7:0] v;
    wr_reg(8'd10, 8'h76);
    wr_reg(8'd11, 8'h02);
    load(8'h02, 8'h04, 8'h58, 8'h02, 8'h02, 8'h11, 8'h20);
    step(3 * TPS);
    check_time("R1", 8'h02, 8'h04, 8'h58, 8'h02, 8'h02, 8'h11, 8'h20);
    rd_status(v);
    wr_reg(8'd10, 8'h26);
    step(HALF - HOLD - 1);
    rd_reg(8'd10, v); chk("R3", "uip before window", v, 8'h26);
    rd_reg(8'd0, v);  chk("R2", "sec before update", v, 8'h58);
    step(1);
    rd_reg(8'd10, v); chk("R3", "uip window start", v, 8'hA6);
    step(HOLD - 1);
    rd_reg(8'd10, v); chk("R3", "uip window end", v, 8'hA6);
    rd_reg(8'd0, v);  chk("R3", "sec held in window", v, 8'h58);
    step(1);
    rd_reg(8'd10, v); chk("R3", "uip after update", v, 8'h26);
    check_time("R2", 8'h02, 8'h04, 8'h59, 8'h02, 8'h02, 8'h11, 8'h20);
    rd_status(v); chk("R7", "update-ended set", v, 8'h10);
    rd_status(v); chk("R7", "cleared by read", v, 8'h00);
  endtask

  task automatic t_set;
    logic [7:0] v;
    wr_reg(8'd11, 8'h82);
    rd_status(v);
    load(8'h02, 8'h04, 8'h58, 8'h02, 8'h02, 8'h11, 8'h20);
    step(2 * TPS);
    check_time("R4", 8'h02, 8'h04, 8'h58, 8'h02, 8'h02, 8'h11, 8'h20);
    rd_reg(8'd10, v); chk("R4", "uip hidden while frozen", v[7], 1'b0);
    rd_status(v); chk("R4", "no flag while frozen", v, 8'h00);
    wr_reg(8'd11, 8'h02);
    step(TPS);
    check_time("R4", 8'h02, 8'h04, 8'h59, 8'h02, 8'h02, 8'h11, 8'h20);
  endtask

  task automatic t_binary;
    wr_reg(8'd10, 8'h76);
    wr_reg(8'd11, 8'h06);
    load(8'd23, 8'd59, 8'd59, 8'd31, 8'd12, 8'd99, 8'd20);
    check_time("R5", 8'd23, 8'd59, 8'd59, 8'd31, 8'd12, 8'd99, 8'd20);
    wr_reg(8'd10, 8'h26);
    step(HALF);
    check_time("R10", 8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd0, 8'd21);
    wr_reg(8'd11, 8'h02);
    check_time("R5", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h21);
  endtask

  task automatic roll(input string req, input logic [7:0] h, mi, s, d, mo, y,
                      input logic [7:0] eh, emi, es, ed, emo, ey);
    wr_reg(8'd10, 8'h76);
    wr_reg(8'd11, 8'h02);
    load(h, mi, s, d, mo, y, 8'h20);
    wr_reg(8'd10, 8'h26);
    step(HALF);
    check_time(req, eh, emi, es, ed, emo, ey, 8'h20);
  endtask

  task automatic t_alarm;
    logic [7:0] v;
    wr_reg(8'd10, 8'h76);
    wr_reg(8'd11, 8'h02);
    load(8'h02, 8'h04, 8'h58, 8'h02, 8'h02, 8'h11, 8'h20);
    wr_reg(8'd5, 8'h02); wr_reg(8'd3, 8'hC0); wr_reg(8'd1, 8'h59);
    rd_status(v);
    wr_reg(8'd10, 8'h26);
    step(HALF);
    rd_status(v); chk("R8", "alarm match", v, 8'h30);
    rd_status(v); chk("R7", "both cleared", v, 8'h00);
    wr_reg(8'd5, 8'h03);
    step(TPS - 3);
    rd_status(v); chk("R8", "alarm miss", v, 8'h10);
  endtask

  task automatic t_uip_stuck;
    logic [7:0] v;
    wr_reg(8'd10, 8'h76);
    load(8'h02, 8'h04, 8'h58, 8'h02, 8'h02, 8'h11, 8'h20);
    wr_reg(8'd5, 8'h02); wr_reg(8'd3, 8'hC0); wr_reg(8'd1, 8'hC0);
    rd_status(v);
    wr_reg(8'd10, 8'h26);
    step(HALF - HOLD / 2);
    rd_reg(8'd10, v); chk("R6", "uip seen", v[7], 1'b1);
    wr_reg(8'd5, 8'h03);
    step(HOLD / 2 - 2);
    rd_reg(8'd10, v); chk("R6", "uip last tick", v[7], 1'b1);
    step(1);
    rd_reg(8'd10, v); chk("R6", "uip cleared", v, 8'h26);
    rd_reg(8'd0, v);  chk("R6", "sec advanced", v, 8'h59);
    rd_status(v); chk("R6", "alarm moved away", v, 8'h10);
  endtask

  task automatic run_all;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_divider();
    t_set();
    t_binary();
    roll("R9", 8'h02, 8'h59, 8'h59, 8'h05, 8'h06, 8'h11, 8'h03, 8'h00, 8'h00, 8'h05, 8'h06, 8'h11);
    roll("R9", 8'h23, 8'h59, 8'h59, 8'h05, 8'h06, 8'h11, 8'h00, 8'h00, 8'h00, 8'h06, 8'h06, 8'h11);
    roll("R10", 8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h24, 8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h24);
    roll("R10", 8'h23, 8'h59, 8'h59, 8'h29, 8'h02, 8'h24, 8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h24);
    roll("R10", 8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h23, 8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h23);
    roll("R10", 8'h23, 8'h59, 8'h59, 8'h30, 8'h04, 8'h23, 8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h23);
    roll("R10", 8'h23, 8'h59, 8'h59, 8'h30, 8'h01, 8'h23, 8'h00, 8'h00, 8'h00, 8'h31, 8'h01, 8'h23);
    roll("R10", 8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h23, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h24);
    t_alarm();
    t_uip_stuck();
  endtask

  initial begin
    fork
      run_all();
      begin
        #(4 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule